// File: doc/BRIEF.md
# Configuration and Serial I/O Port Decoder

This block sits on the I/O side of an 8-bit processor bus that has 256 port numbers. It looks at the low address byte of each I/O cycle and at the read and write strobes. It then drives one of two registered chip selects. One goes to a slow battery-backed configuration RAM. The other goes to an asynchronous serial adapter that has separate read-only and write-only register banks. With each select it also drives a register index and a direction flag.

The configuration RAM cannot answer within a normal I/O cycle. Every access that is granted to it therefore raises a wait request for exactly one clock. A power-good input gates the RAM select. The select drops in the same cycle that power-good falls. It is granted again only after power-good has been high for a settling interval, so the RAM never sees an undefined bus.

A port that reaches no device gets no select and no wait. A read of such a port presents 0xFF on a small idle-bus driver. There is no data stream here: every pin is a plain level control or status signal, so no valid/ready handshake applies and no back-pressure exists.

Top module: `cfg_io_decoder`

## Requirements
- R1: An I/O access (io_req high with rd_stb or wr_stb high) to port 0x00..0x7F, sampled at a clock edge while power is settled, raises cram_sel after that edge. reg_idx then equals port[6:0], and the select stays high for as long as the access is held.
- R2: Each granted configuration-RAM access raises wait_req in the same cycle as cram_sel, for exactly one clock. wait_req then stays low for the rest of that access.
- R3: A read of port 0xA0..0xA3 or a write of port 0xA4..0xA7 raises ser_sel after the sampling edge, with reg_idx = port[1:0]. Port bit 2 = 0 is the read-only bank and bit 2 = 1 is the write-only bank.
- R4: A write to 0xA0..0xA3 or a read of 0xA4..0xA7 (wrong bank for the direction) raises no select and no wait.
- R5: While pwr_good is low, cram_sel is low in that same cycle, even in the middle of an access. No RAM access is granted and wait_req is not raised.
- R6: After pwr_good returns high, no RAM access is granted until pwr_good has been sampled high on PG_SETTLE consecutive edges.
- R7: An access that selects no device (ports 0x80..0x9F, 0xA8..0xFF, a wrong-bank serial access, or a RAM access while power is not settled) raises no select and no wait. If it is a read, idle_rd_en is 1 and idle_rd_data is 0xFF. Otherwise idle_rd_en is 0 and idle_rd_data is 0x00.
- R8: While rst is high at a clock edge, all selects, wait_req and idle_rd_en are low after that edge, and the power settling count restarts.
- R9: dir_wr is 1 for a write access and 0 for a read access. All selects and dir_wr drop after the first edge at which the access is no longer present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good | input | 1 | Supply good; low means the buses may become undefined |
| io_port | input | PORT_W | Low address byte of the I/O cycle |
| io_req | input | 1 | I/O cycle in progress |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| cram_sel | output | 1 | Configuration RAM select |
| ser_sel | output | 1 | Serial adapter select |
| reg_idx | output | IDX_W | Register index inside the selected device |
| dir_wr | output | 1 | 1 = write, 0 = read |
| wait_req | output | 1 | Cycle stretch request to the processor |
| idle_rd_en | output | 1 | Drive the idle-bus value onto the read data |
| idle_rd_data | output | DATA_W | Idle-bus read value |

## Verification
The bench builds the block with its default parameters: an 8-bit port, a RAM window ending at 0x7F, the serial window at 0xA0 with eight registers, and a power settling interval of 4 clocks. The short interval makes both sides of R6 reachable in a few cycles. An access issued as power returns is refused, and one issued after the interval is granted. The window edges at 0x7F, 0x80, 0x9F, 0xA8 and 0xFF are all within reach, as is each serial bank in both directions.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CRAM = 2'd1,
    RGN_SER  = 2'd2
  } region_e;
endpackage

// File: rtl/cfg_io_classify.sv
module cfg_io_classify
  import cfg_io_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int CRAM_TOP      = 127,
  parameter int SER_BASE      = 160,
  parameter int SER_SPAN_LOG2 = 3
) (
  input  logic [PORT_W-1:0] port,
  input  logic              is_wr,
  output region_e           region
);
  localparam logic [PORT_W-1:0] CRAM_TOP_P = PORT_W'(CRAM_TOP);
  localparam logic [PORT_W-1:0] SER_BASE_P = PORT_W'(SER_BASE);
  localparam int BANK_BIT = SER_SPAN_LOG2 - 1;

  logic cram_hit, ser_hit, bank_ok;

  always_comb begin
    cram_hit = (port <= CRAM_TOP_P);
    ser_hit  = (port[PORT_W-1:SER_SPAN_LOG2] == SER_BASE_P[PORT_W-1:SER_SPAN_LOG2]);
    // upper half of the serial window is the write-only bank
    bank_ok  = (port[BANK_BIT] == is_wr);
    if (cram_hit)             region = RGN_CRAM;
    else if (ser_hit && bank_ok) region = RGN_SER;
    else                      region = RGN_NONE;
  end
endmodule

// File: rtl/cfg_io_pwr_gate.sv
module cfg_io_pwr_gate #(
  parameter int PG_SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  output logic pg_ok
);
  localparam int CNT_W = $clog2(PG_SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PG_SETTLE);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // falling supply removes the grant without waiting for a clock
  assign pg_ok = pwr_good && (cnt_q == CNT_MAX);

  // R6: the first sampled-high cycle after an outage never grants
  a_r6_no_grant_on_return: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> !pg_ok);
endmodule

// File: rtl/cfg_io_wait.sv
module cfg_io_wait (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic grant,
  output logic wait_req
);
  logic active_q, wait_q;
  logic first;

  assign first = active && !active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      active_q <= active;
      wait_q   <= first && grant;
    end
  end

  assign wait_req = wait_q;

  // R2: one stretch clock per access, never two in a row
  a_r2_wait_single: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> !wait_req);
endmodule

// File: rtl/cfg_io_decoder.sv
module cfg_io_decoder
  import cfg_io_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int DATA_W        = 8,
  parameter int CRAM_TOP      = 127,
  parameter int SER_BASE      = 160,
  parameter int SER_SPAN_LOG2 = 3,
  parameter int PG_SETTLE     = 4,
  localparam int IDX_W        = $clog2(CRAM_TOP + 1),
  localparam int SER_IDX_W    = SER_SPAN_LOG2 - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic [PORT_W-1:0] io_port,
  input  logic              io_req,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic              cram_sel,
  output logic              ser_sel,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              dir_wr,
  output logic              wait_req,
  output logic              idle_rd_en,
  output logic [DATA_W-1:0] idle_rd_data
);
  region_e region;
  logic    active, pg_ok, cram_grant;
  logic    cram_q, ser_q, dir_q, idle_q;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign active = io_req && (rd_stb || wr_stb);

  cfg_io_classify #(
    .PORT_W(PORT_W), .CRAM_TOP(CRAM_TOP),
    .SER_BASE(SER_BASE), .SER_SPAN_LOG2(SER_SPAN_LOG2)
  ) u_classify (
    .port(io_port), .is_wr(wr_stb), .region(region)
  );

  cfg_io_pwr_gate #(.PG_SETTLE(PG_SETTLE)) u_pwr (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .pg_ok(pg_ok)
  );

  assign cram_grant = (region == RGN_CRAM) && pg_ok;

  cfg_io_wait u_wait (
    .clk(clk), .rst(rst), .active(active), .grant(cram_grant),
    .wait_req(wait_req)
  );

  always_comb begin
    case (region)
      RGN_CRAM: idx_d = io_port[IDX_W-1:0];
      RGN_SER:  idx_d = {{(IDX_W-SER_IDX_W){1'b0}}, io_port[SER_IDX_W-1:0]};
      default:  idx_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cram_q <= 1'b0;
      ser_q  <= 1'b0;
      dir_q  <= 1'b0;
      idle_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      cram_q <= cram_grant;
      ser_q  <= (region == RGN_SER);
      dir_q  <= wr_stb;
      idle_q <= rd_stb && !wr_stb && !cram_grant && (region != RGN_SER);
      idx_q  <= idx_d;
    end
  end

  assign cram_sel     = cram_q && pg_ok;
  assign ser_sel      = ser_q;
  assign reg_idx      = idx_q;
  assign dir_wr       = dir_q;
  assign idle_rd_en   = idle_q;
  assign idle_rd_data = idle_q ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  // R5: supply loss removes the RAM select in the same cycle
  a_r5_pg_forces_off: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |-> !cram_sel);
  // R3: never two devices at once
  a_r3_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cram_sel && ser_sel));
  // R2: a stretch only accompanies a live RAM select
  a_r2_wait_with_sel: assert property (@(posedge clk) disable iff (rst)
    (wait_req && pwr_good) |-> cram_sel);
  // R7: idle-bus driver only when nothing is selected
  a_r7_idle_excl: assert property (@(posedge clk) disable iff (rst)
    idle_rd_en |-> (!cram_sel && !ser_sel && !wait_req));
  // R8: reset clears every output
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!cram_sel && !ser_sel && !wait_req && !idle_rd_en));
endmodule

// File: tb/cfg_io_decoder_tb.sv
module cfg_io_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1;
  logic [7:0] io_port = '0;
  logic io_req = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic cram_sel, ser_sel, dir_wr, wait_req, idle_rd_en;
  logic [6:0] reg_idx;
  logic [7:0] idle_rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // first cycle after sampling edge, second cycle, cycle after release
  logic s1_cram, s1_ser, s1_wait, s1_dir, s1_idle;
  logic [6:0] s1_idx;
  logic [7:0] s1_data;
  logic s2_cram, s2_wait, s3_cram, s3_ser, s3_dir;

  always #4 clk = ~clk;

  cfg_io_decoder dut_i (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .io_port(io_port),
    .io_req(io_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .cram_sel(cram_sel), .ser_sel(ser_sel), .reg_idx(reg_idx),
    .dir_wr(dir_wr), .wait_req(wait_req), .idle_rd_en(idle_rd_en),
    .idle_rd_data(idle_rd_data)
  );

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic run_access(input logic [7:0] p, input logic w);
    @(negedge clk);
    io_port = p; wr_stb = w; rd_stb = !w; io_req = 1'b1;
    @(negedge clk);
    s1_cram = cram_sel; s1_ser = ser_sel; s1_wait = wait_req; s1_dir = dir_wr;
    s1_idle = idle_rd_en; s1_idx = reg_idx; s1_data = idle_rd_data;
    @(negedge clk);
    s2_cram = cram_sel; s2_wait = wait_req;
    io_req = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    @(negedge clk);
    s3_cram = cram_sel; s3_ser = ser_sel; s3_dir = dir_wr;
  endtask

  task automatic t_reset();
    io_port = 8'h12; io_req = 1'b1; rd_stb = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 cram_sel in reset", cram_sel, 0);
    check("R8 wait_req in reset", wait_req, 0);
    check("R8 idle_rd_en in reset", idle_rd_en, 0);
    io_req = 1'b0; rd_stb = 1'b0;
    rst = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_ram();
    run_access(8'h23, 1'b0);
    check("R1 cram_sel read 0x23", s1_cram, 1);
    check("R1 reg_idx 0x23", s1_idx, 'h23);
    check("R3 ser_sel during RAM", s1_ser, 0);
    check("R2 wait first cycle", s1_wait, 1);
    check("R2 wait second cycle", s2_wait, 0);
    check("R1 select held", s2_cram, 1);
    check("R9 dir read", s1_dir, 0);
    check("R9 select drops", s3_cram, 0);
    run_access(8'h7F, 1'b1);
    check("R1 cram_sel write 0x7F", s1_cram, 1);
    check("R1 reg_idx 0x7F", s1_idx, 'h7F);
    check("R2 wait on write", s1_wait, 1);
    check("R9 dir write", s1_dir, 1);
    check("R9 dir drops", s3_dir, 0);
  endtask

  task automatic t_serial();
    run_access(8'hA1, 1'b0);
    check("R3 ser_sel read 0xA1", s1_ser, 1);
    check("R3 reg_idx 0xA1", s1_idx, 1);
    check("R3 no wait serial", s1_wait, 0);
    check("R9 ser drops", s3_ser, 0);
    run_access(8'hA6, 1'b1);
    check("R3 ser_sel write 0xA6", s1_ser, 1);
    check("R3 reg_idx 0xA6", s1_idx, 2);
    check("R9 dir write serial", s1_dir, 1);
  endtask

  task automatic t_bank();
    run_access(8'hA5, 1'b0);
    check("R4 read of write bank no sel", s1_ser, 0);
    check("R7 wrong bank read idle", s1_idle, 1);
    check("R7 wrong bank read data", s1_data, 'hFF);
    run_access(8'hA2, 1'b1);
    check("R4 write of read bank no sel", s1_ser, 0);
    check("R4 write of read bank no wait", s1_wait, 0);
    check("R7 write not idle", s1_idle, 0);
  endtask

  task automatic t_unmapped();
    run_access(8'h80, 1'b0);
    check("R7 0x80 no cram", s1_cram, 0);
    check("R7 0x80 no wait", s1_wait, 0);
    check("R7 0x80 data", s1_data, 'hFF);
    run_access(8'h9F, 1'b0);
    check("R7 0x9F no ser", s1_ser, 0);
    check("R7 0x9F idle", s1_idle, 1);
    run_access(8'hA8, 1'b0);
    check("R7 0xA8 no ser", s1_ser, 0);
    run_access(8'hFF, 1'b1);
    check("R7 0xFF write idle off", s1_idle, 0);
    check("R7 0xFF write data", s1_data, 0);
  endtask

  task automatic t_power();
    // mid-access drop
    @(negedge clk);
    io_port = 8'h05; rd_stb = 1'b1; io_req = 1'b1;
    @(negedge clk);
    check("R1 select before drop", cram_sel, 1);
    pwr_good = 1'b0;
    #1;
    check("R5 select drops with supply", cram_sel, 0);
    io_req = 1'b0; rd_stb = 1'b0;
    repeat (2) @(negedge clk);
    run_access(8'h10, 1'b0);
    check("R5 no select while down", s1_cram, 0);
    check("R5 no wait while down", s1_wait, 0);
    check("R7 refused read idle", s1_data, 'hFF);
    // return: access starts with supply
    @(negedge clk);
    pwr_good = 1'b1;
    io_port = 8'h11; wr_stb = 1'b1; io_req = 1'b1;
    @(negedge clk);
    check("R6 no grant on return", cram_sel, 0);
    check("R6 no wait on return", wait_req, 0);
    io_req = 1'b0; wr_stb = 1'b0;
    repeat (6) @(negedge clk);
    run_access(8'h11, 1'b1);
    check("R6 granted after settle", s1_cram, 1);
    check("R6 wait after settle", s1_wait, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ram();
    t_serial();
    t_bank();
    t_unmapped();
    t_power();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule